// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers 32 interrupt request lines and turns them into the two request lines of a processor core: a fast line (`fiq`) and a normal line (`irq`). Software sorts every source into one of three classes through registers. A source flagged as fast goes to `fiq`, which always outranks the normal line. A source bound to one of 16 ordered vector slots becomes a vectored request. Any other enabled source is a non-vectored request and has the lowest rank.

When the interrupt handler reads the vector register, it gets the handler address held by the best pending slot, or a shared default address when only non-vectored requests are waiting. That read also latches the priority level being served. From then on, only slots of better rank can raise `irq`, until software writes the vector register to end service. There is one level of end-of-service. No stack of nested levels is kept.

All register accesses use a single-cycle write port and a read port. Read data is registered and is valid in the cycle after `rd_en`.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Register word addresses (32-bit data): 0 IRQ status (read only), 1 FIQ status (read only), 2 enable mask, 3 fast-select mask, 4 vector register (a read returns an address and locks the level; a write of any value ends service), 5 default address, 16+k slot k control (bits 4:0 source number, bit 5 slot enable), 32+k slot k handler address. Read data appears on `rd_data` one cycle after `rd_en`. Writes take effect at the clock edge.
- R2: `fiq` is high exactly when some source has its request, enable and fast-select bits all set. FIQ status reads that set of sources.
- R3: A source whose enable bit is 0 changes neither output nor either status word.
- R4: IRQ status reads the sources that are requesting, enabled and not fast-selected. With no level locked, `irq` is high whenever that set is not empty.
- R5: A vector read returns the address of the lowest-numbered enabled slot whose source is in the IRQ status set. If two slots name the same source, the lower-numbered slot wins.
- R6: A vector read with no pending vectored slot returns the default address.
- R7: A slot whose enable bit is 0 is ignored. Its source then counts as non-vectored.
- R8: After a vector read that returned slot k, `irq` reflects only slots numbered below k. A read that returned the default masks non-vectored requests. In both cases the mask holds until end of service.
- R9: A write to the vector register restores full IRQ signalling in the next cycle.
- R10: A fast-selected source held in a slot never produces that slot's vector address.
- R11: Reset clears every register. The default address is 0 and no level is locked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 32 | Raw request lines, one per source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 6 | Register read word address |
| rd_data | output | 32 | Registered read data |
| fiq | output | 1 | Fast interrupt request to the core |
| irq | output | 1 | Normal interrupt request to the core |

## Verification
The hardest state to reach is a locked priority level with a mix of pending requests: some above the lock, some below it, and some non-vectored. The bench reaches it by reading the vector with two slotted sources pending, so the better slot gets locked. It then confirms that `irq` drops even though requests are still asserted. Next it raises a source held by an even better slot and checks that `irq` comes back and that a second read returns that slot. An exhaustive sweep over all slot pairs covers slot ordering. Rebinding two slots to one source covers the duplicate case.

// File: rtl/irq_vector_pkg.sv
`timescale 1ns/1ps
package irq_vector_pkg;
    localparam int N_SRC  = 32;
    localparam int N_SLOT = 16;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 6;
    localparam int SRC_W  = $clog2(N_SRC);
    localparam int SLOT_W = $clog2(N_SLOT);
    localparam int LVL_W  = $clog2(N_SLOT + 2);

    localparam logic [LVL_W-1:0] LVL_DEFAULT = LVL_W'(N_SLOT);
    localparam logic [LVL_W-1:0] LVL_IDLE    = LVL_W'(N_SLOT + 1);

    localparam logic [ADDR_W-1:0] SLOT_CTL_BASE = ADDR_W'(16);
    localparam logic [ADDR_W-1:0] SLOT_ADR_BASE = ADDR_W'(32);

    typedef enum logic [ADDR_W-1:0] {
        A_IRQ_STAT = 6'd0,
        A_FIQ_STAT = 6'd1,
        A_ENABLE   = 6'd2,
        A_FIQ_SEL  = 6'd3,
        A_VECTOR   = 6'd4,
        A_DEFAULT  = 6'd5
    } reg_addr_e;

    typedef struct packed {
        logic             on;
        logic [SRC_W-1:0] src;
    } slot_cfg_t;

    typedef struct packed {
        logic              hit;
        logic [SLOT_W-1:0] idx;
    } slot_pick_t;

    function automatic logic in_window(logic [ADDR_W-1:0] a, logic [ADDR_W-1:0] base);
        return (a >= base) && (a < base + ADDR_W'(N_SLOT));
    endfunction
endpackage

// File: rtl/ivc_classify.sv
`timescale 1ns/1ps
module ivc_classify
    import irq_vector_pkg::*;
(
    input  logic [N_SRC-1:0] req,
    input  logic [N_SRC-1:0] en,
    input  logic [N_SRC-1:0] fsel,
    input  slot_cfg_t        cfg [N_SLOT],
    output logic [N_SRC-1:0] fiq_pend,
    output logic [N_SRC-1:0] irq_pend,
    output logic [N_SRC-1:0] nonvec_pend
);
    logic [N_SRC-1:0] live;
    logic [N_SRC-1:0] slotted;

    assign live     = req & en;
    assign fiq_pend = live & fsel;
    assign irq_pend = live & ~fsel;

    always_comb begin
        slotted = '0;
        for (int k = 0; k < N_SLOT; k++) begin
            if (cfg[k].on) slotted[cfg[k].src] = 1'b1;
        end
    end

    assign nonvec_pend = irq_pend & ~slotted;
endmodule

// File: rtl/ivc_slot_arb.sv
`timescale 1ns/1ps
module ivc_slot_arb
    import irq_vector_pkg::*;
(
    input  logic [N_SRC-1:0] irq_pend,
    input  slot_cfg_t        cfg [N_SLOT],
    input  logic [LVL_W-1:0] lvl,
    output slot_pick_t       pick
);
    logic [N_SLOT-1:0] ready;

    for (genvar k = 0; k < N_SLOT; k++) begin : g_slot
        assign ready[k] = cfg[k].on && irq_pend[cfg[k].src] && (LVL_W'(k) < lvl);
    end

    always_comb begin
        pick = '0;
        for (int k = N_SLOT - 1; k >= 0; k--) begin
            if (ready[k]) begin
                pick.hit = 1'b1;
                pick.idx = SLOT_W'(k);
            end
        end
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
`timescale 1ns/1ps
module irq_vector_ctrl
    import irq_vector_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       irq_req,
    input  logic              wr_en,
    input  logic [5:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              rd_en,
    input  logic [5:0]        rd_addr,
    output logic [31:0]       rd_data,
    output logic              fiq,
    output logic              irq
);
    logic [N_SRC-1:0]  en_q;
    logic [N_SRC-1:0]  fiqsel_q;
    logic [DATA_W-1:0] dflt_q;
    slot_cfg_t         slot_cfg_q [N_SLOT];
    logic [DATA_W-1:0] slot_adr_q [N_SLOT];
    logic [LVL_W-1:0]  lvl_q;
    logic [DATA_W-1:0] rd_data_q;

    logic [N_SRC-1:0]  fiq_pend, irq_pend, nonvec_pend;
    slot_pick_t        pick;
    logic [DATA_W-1:0] rd_next;
    logic [SLOT_W-1:0] wr_slot, rd_slot;
    logic              vec_read, eos_write;

    ivc_classify u_class (
        .req         (irq_req),
        .en          (en_q),
        .fsel        (fiqsel_q),
        .cfg         (slot_cfg_q),
        .fiq_pend    (fiq_pend),
        .irq_pend    (irq_pend),
        .nonvec_pend (nonvec_pend)
    );

    ivc_slot_arb u_arb (
        .irq_pend (irq_pend),
        .cfg      (slot_cfg_q),
        .lvl      (lvl_q),
        .pick     (pick)
    );

    assign fiq = |fiq_pend;
    assign irq = pick.hit || ((|nonvec_pend) && (lvl_q == LVL_IDLE));

    assign wr_slot   = wr_addr[SLOT_W-1:0];
    assign rd_slot   = rd_addr[SLOT_W-1:0];
    assign vec_read  = rd_en && (rd_addr == A_VECTOR);
    assign eos_write = wr_en && (wr_addr == A_VECTOR);

    always_comb begin
        rd_next = '0;
        if (in_window(rd_addr, SLOT_CTL_BASE)) begin
            rd_next = DATA_W'(slot_cfg_q[rd_slot]);
        end else if (in_window(rd_addr, SLOT_ADR_BASE)) begin
            rd_next = slot_adr_q[rd_slot];
        end else begin
            case (rd_addr)
                A_IRQ_STAT: rd_next = irq_pend;
                A_FIQ_STAT: rd_next = fiq_pend;
                A_ENABLE:   rd_next = en_q;
                A_FIQ_SEL:  rd_next = fiqsel_q;
                A_VECTOR:   rd_next = pick.hit ? slot_adr_q[pick.idx] : dflt_q;
                A_DEFAULT:  rd_next = dflt_q;
                default:    rd_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q      <= '0;
            fiqsel_q  <= '0;
            dflt_q    <= '0;
            lvl_q     <= LVL_IDLE;
            rd_data_q <= '0;
            for (int k = 0; k < N_SLOT; k++) begin
                slot_cfg_q[k] <= '0;
                slot_adr_q[k] <= '0;
            end
        end else begin
            if (rd_en) rd_data_q <= rd_next;
            if (wr_en) begin
                if (in_window(wr_addr, SLOT_CTL_BASE)) begin
                    slot_cfg_q[wr_slot] <= wr_data[SRC_W:0];
                end else if (in_window(wr_addr, SLOT_ADR_BASE)) begin
                    slot_adr_q[wr_slot] <= wr_data;
                end else begin
                    case (wr_addr)
                        A_ENABLE:  en_q     <= wr_data;
                        A_FIQ_SEL: fiqsel_q <= wr_data;
                        A_DEFAULT: dflt_q   <= wr_data;
                        default:   ;
                    endcase
                end
            end
            if (eos_write) begin
                lvl_q <= LVL_IDLE;
            end else if (vec_read) begin
                if (pick.hit)                 lvl_q <= LVL_W'(pick.idx);
                else if (lvl_q > LVL_DEFAULT) lvl_q <= LVL_DEFAULT;
            end
        end
    end

    assign rd_data = rd_data_q;
endmodule

// File: rtl/ivc_checker.sv
`timescale 1ns/1ps
module ivc_checker
    import irq_vector_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [31:0]       irq_req,
    input logic              fiq,
    input logic              irq,
    input logic              wr_en,
    input logic [5:0]        wr_addr,
    input logic [N_SRC-1:0]  en_q,
    input logic [N_SRC-1:0]  fiqsel_q,
    input logic [LVL_W-1:0]  lvl_q
);
    AST_FIQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        fiq |-> |(irq_req & en_q & fiqsel_q)); // R2

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        irq |-> |(irq_req & en_q & ~fiqsel_q)); // R4

    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (rst)
        (en_q == '0) |-> (!fiq && !irq)); // R3

    AST_LEVEL_NO_RISE: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_addr == A_VECTOR) |=> (lvl_q <= $past(lvl_q))); // R8

    AST_EOS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_VECTOR) |=> (lvl_q == LVL_IDLE)); // R9
endmodule

bind irq_vector_ctrl ivc_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .irq_req  (irq_req),
    .fiq      (fiq),
    .irq      (irq),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .en_q     (en_q),
    .fiqsel_q (fiqsel_q),
    .lvl_q    (lvl_q)
);

// File: tb/irq_vector_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] irq_req = '0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [5:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        fiq, irq;

    int checks = 0;
    int errors = 0;
    logic        m_on  [16];
    logic [4:0]  m_src [16];
    logic [31:0] m_en = '0, m_fsel = '0;
    localparam logic [31:0] DFLT = 32'hDEAD_BEE0;

    always #4 clk = ~clk;

    irq_vector_ctrl u_dut (
        .clk(clk), .rst(rst), .irq_req(irq_req),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .fiq(fiq), .irq(irq)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
        #1;
    endtask

    task automatic set_req(logic [31:0] v);
        irq_req = v;
        #1;
    endtask

    function automatic logic [31:0] slot_adr(int k);
        return 32'hA000_0000 + 32'(k) * 32'h100;
    endfunction

    function automatic logic [31:0] exp_vector(logic [31:0] r);
        for (int k = 0; k < 16; k++)
            if (m_on[k] && r[m_src[k]] && m_en[m_src[k]] && !m_fsel[m_src[k]])
                return slot_adr(k);
        return DFLT;
    endfunction

    task automatic set_slot(int k, logic on, logic [4:0] s);
        m_on[k] = on; m_src[k] = s;
        wr(6'(16 + k), {26'd0, on, s});
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R11: reset state
        set_req('1);
        check("R11 fiq", {31'd0, fiq}, 0);
        check("R11 irq", {31'd0, irq}, 0);
        rd(6'd2, d); check("R11 enable", d, 0);
        rd(6'd3, d); check("R11 fsel", d, 0);
        rd(6'd5, d); check("R11 default", d, 0);
        rd(6'd20, d); check("R11 slot ctl", d, 0);
        rd(6'd4, d); check("R11 R6 vector", d, 0);
        wr(6'd4, 0);

        // R2 R3 R4: per-source sweep
        for (int s = 0; s < 32; s++) begin
            wr(6'd2, 32'd1 << s);
            wr(6'd3, 32'd1 << s);
            check("R2 fiq", {31'd0, fiq}, 1);
            check("R4 irq off", {31'd0, irq}, 0);
            rd(6'd1, d); check("R2 fiq status", d, 32'd1 << s);
            rd(6'd0, d); check("R4 irq status", d, 0);
            wr(6'd3, ~(32'd1 << s));
            check("R2 fiq off", {31'd0, fiq}, 0);
            check("R4 irq", {31'd0, irq}, 1);
            rd(6'd0, d); check("R4 irq status", d, 32'd1 << s);
            wr(6'd2, 0);
            check("R3 fiq", {31'd0, fiq}, 0);
            check("R3 irq", {31'd0, irq}, 0);
            rd(6'd1, d); check("R3 fiq status", d, 0);
            rd(6'd0, d); check("R3 irq status", d, 0);
        end
        wr(6'd3, 0);
        set_req(0);

        // R1 R5: program slots and sweep all pairs
        m_en = '1; m_fsel = '0;
        wr(6'd2, '1);
        wr(6'd5, DFLT);
        for (int k = 0; k < 16; k++) begin
            set_slot(k, 1'b1, 5'((k * 7 + 3) % 32));
            wr(6'(32 + k), slot_adr(k));
        end
        rd(6'd37, d); check("R1 slot adr readback", d, slot_adr(5));
        rd(6'd21, d); check("R1 slot ctl readback", d, {26'd0, 1'b1, m_src[5]});
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                set_req((32'd1 << m_src[a]) | (32'd1 << m_src[b]));
                rd(6'd4, d);
                check("R5 pair vector", d, slot_adr(a < b ? a : b));
                wr(6'd4, 0);
            end
        end

        // R6: only non-vectored source 0 pending
        set_req(32'd1);
        check("R4 nonvec irq", {31'd0, irq}, 1);
        rd(6'd4, d); check("R6 default", d, DFLT);
        check("R8 nonvec masked", {31'd0, irq}, 0);
        wr(6'd4, 0);
        check("R9 irq back", {31'd0, irq}, 1);

        // R8 R9: level lock and preemption
        set_req((32'd1 << m_src[5]) | (32'd1 << m_src[10]) | 32'd1);
        rd(6'd4, d); check("R8 first vector", d, slot_adr(5));
        check("R8 lower masked", {31'd0, irq}, 0);
        set_req(irq_req | (32'd1 << m_src[2]));
        check("R8 higher preempts", {31'd0, irq}, 1);
        rd(6'd4, d); check("R8 second vector", d, slot_adr(2));
        check("R8 masked again", {31'd0, irq}, 0);
        wr(6'd4, 0);
        check("R9 eos irq", {31'd0, irq}, 1);
        rd(6'd4, d); check("R9 vector after eos", d, slot_adr(2));
        wr(6'd4, 0);

        // R7: disabled slot ignored
        set_slot(2, 1'b0, m_src[2]);
        set_req(32'd1 << m_src[2]);
        check("R7 irq as nonvec", {31'd0, irq}, 1);
        rd(6'd4, d); check("R7 disabled slot", d, exp_vector(irq_req));
        check("R7 model default", d, DFLT);
        wr(6'd4, 0);
        set_slot(2, 1'b1, m_src[2]);

        // R5: duplicate source, lower slot wins
        set_slot(9, 1'b1, m_src[4]);
        set_req(32'd1 << m_src[4]);
        rd(6'd4, d); check("R5 duplicate", d, slot_adr(4));
        wr(6'd4, 0);
        set_slot(4, 1'b0, m_src[4]);
        rd(6'd4, d); check("R7 duplicate fallback", d, slot_adr(9));
        wr(6'd4, 0);

        // R10: fast-selected source in a slot
        m_fsel = 32'd1 << m_src[3];
        wr(6'd3, m_fsel);
        set_req(32'd1 << m_src[3]);
        check("R10 fiq", {31'd0, fiq}, 1);
        check("R10 irq", {31'd0, irq}, 0);
        rd(6'd4, d); check("R10 vector", d, DFLT);
        wr(6'd4, 0);
        rd(6'd1, d); check("R10 fiq status", d, m_fsel);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule